// File: doc/BRIEF.md
# Addressed Serial Slave for Display Latches and Key Readout

This block is a synchronous three-wire serial slave with an open-drain style return line. A host shifts an 8-bit selector byte in least-significant bit first while the enable line is low. When the host raises enable, the selector fixes the transfer type for the rest of the frame. One selector value opens a write frame. A write frame carries half of the segment image, the seven mode bits and a flag that says which half of the image the frame fills. The other selector value opens a read frame. A read frame returns the thirty key bits and the sleep-acknowledge bit. The latched image and the mode fields feed the display and the key scanner, which sit next to this block.

All serial pins are oversampled by the system clock through synchronisers, and all work is done on the edges found that way. A write is committed only when enable falls, and only if the frame held exactly the expected number of bits. Between frames the return line shows the key scanner's pending request. When a read frame ends with a request pending, the block sends a one-cycle strobe back to the scanner so that it can clear the request. The chip-level reset input only masks that request indication. Frames keep working while it is asserted.

Top module: `keyled_serial_slave`

## Requirements
- R1: Only a selector byte of 0x42 (write) or 0x43 (read), shifted LSB first on rising `ser_clk` while `ser_ce` is low, opens a frame. Any other byte makes the following enable-high frame change no latch and return nothing.
- R2: A write payload is 53 bits, first bit = bit 0. Bits 0–44 are segment bits. Bits 45–51 are `sleep_mode[0]`, `sleep_mode[1]`, `keyout_sel[0]`, `keyout_sel[1]`, `port_sel[0]`, `port_sel[1]` and `seg_off`. Bit 52 is the half flag. On the fall of `ser_ce`, flag 0 loads `disp_bits[44:0]` and the mode fields, and flag 1 loads `disp_bits[89:45]`.
- R3: A write with half flag 1 leaves all mode fields unchanged.
- R4: A write frame whose bit count is not exactly 53 (shorter or longer) changes no latch.
- R5: In a read frame, `ser_do_low` carries KD1..KD30 (`key_bits[0]`..`key_bits[29]`) and then `sleep_ack`. A 1 is shown as released (`ser_do_low`=0). The first bit appears after enable rises and before the first clock. Each later bit appears after a falling `ser_clk`, so the host samples on rising edges.
- R6: A read frame opened while `key_req` is low shifts out only zeros and produces no `read_done`.
- R7: While `ser_ce` is low, `ser_do_low` is 1 exactly when `key_req` is 1 and `chip_rst_n` is 1.
- R8: While `ser_ce` is high in any frame other than a read, `ser_do_low` is 0.
- R9: The fall of `ser_ce` that ends a read frame opened with `key_req` high gives a `read_done` pulse exactly one clock long, once.
- R10: Write frames update the latches while `chip_rst_n` is low.
- R11: After `rst_n` the segment image and the mode fields are all zero, `ser_do_low` is 0 and `read_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Power-on reset, active low |
| chip_rst_n | input | 1 | Chip-level reset, active low; masks only the request indication |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_ce | input | 1 | Frame enable from the host |
| ser_di | input | 1 | Serial data from the host |
| ser_do_low | output | 1 | 1 pulls the shared return line low, 0 releases it |
| key_bits | input | 30 | Key matrix state from the scanner, bit 0 = KD1 |
| sleep_ack | input | 1 | Sleep-acknowledge bit from the scanner |
| key_req | input | 1 | Key-read request from the scanner |
| read_done | output | 1 | One-cycle strobe after a completed key read |
| disp_bits | output | 90 | Latched segment image, bit 0 = first segment bit |
| sleep_mode | output | 2 | Sleep and standby selection field |
| keyout_sel | output | 2 | Scan-line or segment selection for the shared pins |
| port_sel | output | 2 | Segment or general-output selection for the first four pins |
| seg_off | output | 1 | Blanks all segments when 1 |

## Verification
A wrong selector decode or bit count makes the segment image or the mode fields differ from the model. The difference shows up within about a dozen system clocks after enable falls, because that is the only moment the latches change. A read shift register that is off by one bit, or loaded at the wrong moment, corrupts the stream on the return line at the first sampled bit it affects. A wrong request gate or strobe condition shows up on `ser_do_low` as soon as enable is low, or as a missing, extra or repeated `read_done` pulse right after enable falls.

// File: rtl/sif_pkg.sv
package sif_pkg;

  localparam int SIF_ADDR_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2
  } mode_t;

  // Selector byte to frame type.
  function automatic mode_t sif_decode(input logic [SIF_ADDR_W-1:0] sel,
                                       input logic [SIF_ADDR_W-1:0] wr_sel,
                                       input logic [SIF_ADDR_W-1:0] rd_sel);
    if (sel == wr_sel)      return MODE_WR;
    else if (sel == rd_sel) return MODE_RD;
    else                    return MODE_IDLE;
  endfunction

  // Bits in one write frame: half image, mode fields, half flag.
  function automatic int sif_wr_len(input int disp_w, input int ctl_w);
    return disp_w / 2 + ctl_w + 1;
  endfunction

  // Bits in one read frame: keys plus acknowledge bit.
  function automatic int sif_rd_len(input int key_w);
    return key_w + 1;
  endfunction

endpackage

// File: rtl/sif_pin_sync.sv
module sif_pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_sync
);

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
    end
    assign pin_sync[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sif_write_path.sv
module sif_write_path
  import sif_pkg::*;
#(
  parameter int DISP_W = 90,
  parameter int CTL_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              frame_end,
  output logic [DISP_W-1:0] disp_q,
  output logic [CTL_W-1:0]  ctl_q
);

  localparam int HALF_W = DISP_W / 2;
  localparam int PAY_W  = sif_wr_len(DISP_W, CTL_W);
  localparam int CNT_W  = $clog2(PAY_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(PAY_W + 1);

  logic [PAY_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             commit_w;
  logic             upper_w;

  assign commit_w = frame_end && (cnt_q == CNT_FULL);
  assign upper_w  = sr_q[PAY_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (frame_start) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      sr_q <= {bit_in, sr_q[PAY_W-1:1]};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
      ctl_q  <= '0;
    end else if (commit_w) begin
      if (upper_w) begin
        disp_q[DISP_W-1:HALF_W] <= sr_q[HALF_W-1:0];
      end else begin
        disp_q[HALF_W-1:0] <= sr_q[HALF_W-1:0];
        ctl_q              <= sr_q[HALF_W +: CTL_W];
      end
    end
  end

  // The image only moves in the cycle after a frame end.
  p_commit_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_q) |-> $past(frame_end));

  // An upper-half frame end never touches the mode fields.
  p_ctl_kept_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && upper_w) |=> $stable(ctl_q));

  // The bit counter saturates one past a full frame.
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER);

endmodule

// File: rtl/sif_read_path.sv
module sif_read_path
  import sif_pkg::*;
#(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_valid,
  input  logic             shift_en,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             sleep_ack,
  output logic             out_bit
);

  localparam int RD_W = sif_rd_len(KEY_W);

  logic [RD_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '1;
    else if (load)     sr_q <= load_valid ? {sleep_ack, key_bits} : '0;
    else if (shift_en) sr_q <= {1'b1, sr_q[RD_W-1:1]};
  end

  assign out_bit = sr_q[0];

  // A read opened without a pending request exposes no key data.
  p_zero_when_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_valid) |=> (sr_q == '0));

endmodule

// File: rtl/keyled_serial_slave.sv
module keyled_serial_slave
  import sif_pkg::*;
#(
  parameter int                    DISP_W      = 90,
  parameter int                    KEY_W       = 30,
  parameter int                    CTL_W       = 7,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [SIF_ADDR_W-1:0] WR_SEL      = 8'h42,
  parameter logic [SIF_ADDR_W-1:0] RD_SEL      = 8'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst_n,
  input  logic              ser_clk,
  input  logic              ser_ce,
  input  logic              ser_di,
  output logic              ser_do_low,
  input  logic [KEY_W-1:0]  key_bits,
  input  logic              sleep_ack,
  input  logic              key_req,
  output logic              read_done,
  output logic [DISP_W-1:0] disp_bits,
  output logic [1:0]        sleep_mode,
  output logic [1:0]        keyout_sel,
  output logic [1:0]        port_sel,
  output logic              seg_off
);

  localparam int N_PINS = 3;

  // Synchronised pins and edge events.
  logic [N_PINS-1:0] pins_s;
  logic sclk_s, ce_s, di_s;
  logic sclk_p, ce_p;
  logic sclk_rise_w, sclk_fall_w, ce_rise_w, ce_fall_w;

  sif_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   ({ser_di, ser_ce, ser_clk}),
    .pin_sync (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign ce_s   = pins_s[1];
  assign di_s   = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      ce_p   <= 1'b0;
    end else begin
      sclk_p <= sclk_s;
      ce_p   <= ce_s;
    end
  end

  assign sclk_rise_w = sclk_s & ~sclk_p;
  assign sclk_fall_w = ~sclk_s & sclk_p;
  assign ce_rise_w   = ce_s & ~ce_p;
  assign ce_fall_w   = ~ce_s & ce_p;

  // Selector capture and frame type.
  logic [SIF_ADDR_W-1:0] sel_q;
  mode_t                 mode_q;
  mode_t                 sel_mode_w;
  logic                  req_seen_q;

  assign sel_mode_w = sif_decode(sel_q, WR_SEL, RD_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      mode_q     <= MODE_IDLE;
      req_seen_q <= 1'b0;
    end else begin
      if (sclk_rise_w && !ce_s) sel_q <= {di_s, sel_q[SIF_ADDR_W-1:1]};
      if (ce_rise_w) begin
        mode_q     <= sel_mode_w;
        req_seen_q <= key_req;
      end else if (ce_fall_w) begin
        mode_q <= MODE_IDLE;
      end
    end
  end

  // Write side.
  logic             wr_shift_w, wr_end_w;
  logic [CTL_W-1:0] ctl_w;

  assign wr_shift_w = sclk_rise_w && ce_s && (mode_q == MODE_WR);
  assign wr_end_w   = ce_fall_w && (mode_q == MODE_WR);

  sif_write_path #(.DISP_W(DISP_W), .CTL_W(CTL_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (ce_rise_w),
    .shift_en    (wr_shift_w),
    .bit_in      (di_s),
    .frame_end   (wr_end_w),
    .disp_q      (disp_bits),
    .ctl_q       (ctl_w)
  );

  assign sleep_mode = ctl_w[1:0];
  assign keyout_sel = ctl_w[3:2];
  assign port_sel   = ctl_w[5:4];
  assign seg_off    = ctl_w[6];

  // Read side.
  logic rd_load_w, rd_shift_w, rd_bit_w;

  assign rd_load_w  = ce_rise_w && (sel_mode_w == MODE_RD);
  assign rd_shift_w = sclk_fall_w && ce_s && (mode_q == MODE_RD);

  sif_read_path #(.KEY_W(KEY_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rd_load_w),
    .load_valid (key_req),
    .shift_en   (rd_shift_w),
    .key_bits   (key_bits),
    .sleep_ack  (sleep_ack),
    .out_bit    (rd_bit_w)
  );

  // Return line: request flag between frames, data during a read.
  always_comb begin
    if (!rst_n)     ser_do_low = 1'b0;
    else if (ce_s)  ser_do_low = (mode_q == MODE_RD) && !rd_bit_w;
    else            ser_do_low = key_req && chip_rst_n;
  end

  // Read-complete strobe to the key scanner.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) read_done <= 1'b0;
    else        read_done <= ce_fall_w && (mode_q == MODE_RD) && req_seen_q;
  end

  // Between frames no frame type is held.
  p_idle_between_frames_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && !ce_fall_w) |-> (mode_q == MODE_IDLE));

  // The strobe is a single cycle.
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done);

  // The strobe only follows the end of a frame.
  p_strobe_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> $past(ce_fall_w));

endmodule

// File: tb/keyled_serial_slave_tb.sv
module keyled_serial_slave_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_rst_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_ce = 1'b0;
  logic        ser_di = 1'b0;
  logic        ser_do_low;
  logic [29:0] key_bits = '0;
  logic        sleep_ack = 1'b0;
  logic        key_req = 1'b0;
  logic        read_done;
  logic [89:0] disp_bits;
  logic [1:0]  sleep_mode, keyout_sel, port_sel;
  logic        seg_off;

  int checks = 0;
  int errors = 0;
  int rd_pulses = 0;
  bit finished = 0;

  logic [89:0] disp_m = '0;
  logic [6:0]  ctl_m = '0;

  always #5 clk = ~clk;

  keyled_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .chip_rst_n(chip_rst_n),
    .ser_clk(ser_clk), .ser_ce(ser_ce), .ser_di(ser_di),
    .ser_do_low(ser_do_low), .key_bits(key_bits), .sleep_ack(sleep_ack),
    .key_req(key_req), .read_done(read_done), .disp_bits(disp_bits),
    .sleep_mode(sleep_mode), .keyout_sel(keyout_sel), .port_sel(port_sel),
    .seg_off(seg_off)
  );

  always @(posedge clk) if (rst_n && read_done) rd_pulses++;

  // {selector[7:0], bit count[5:0], flag, mode bits[6:0], segments[44:0]}
  localparam logic [66:0] VEC [0:5] = '{
    {8'h42, 6'd53, 1'b0, 7'b1010011, 45'h1234_5678_9AB},
    {8'h42, 6'd53, 1'b1, 7'b0000000, 45'h0FED_CBA9_876},
    {8'h41, 6'd53, 1'b0, 7'h7F,      45'h1FFF_FFFF_FFFF},
    {8'h42, 6'd52, 1'b0, 7'h7F,      45'h0},
    {8'h42, 6'd54, 1'b1, 7'h00,      45'h0},
    {8'h42, 6'd53, 1'b0, 7'b0101100, 45'h0AAA_AAAA_AAAA}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ctl_now();
    return {seg_off, port_sel, keyout_sel, sleep_mode};
  endfunction

  task automatic clock_bit(input logic b);
    ser_di = b;
    wait_cyc(HALF);
    ser_clk = 1'b1;
    wait_cyc(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic send_sel(input logic [7:0] sel);
    ser_ce = 1'b0;
    for (int i = 0; i < 8; i++) clock_bit(sel[i]);
    wait_cyc(HALF);
    ser_ce = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic send_payload(input logic [52:0] pay, input int n);
    for (int i = 0; i < n; i++) clock_bit((i < 53) ? pay[i] : 1'b0);
    wait_cyc(HALF);
    ser_ce = 1'b0;
    wait_cyc(12);
  endtask

  task automatic model_write(input logic [7:0] sel, input int n, input logic [52:0] pay);
    if (sel == 8'h42 && n == 53) begin
      if (pay[52]) disp_m[89:45] = pay[44:0];
      else begin
        disp_m[44:0] = pay[44:0];
        ctl_m        = pay[51:45];
      end
    end
  endtask

  // Returns the number of stream bits that mismatch.
  task automatic do_read(input logic [30:0] exp_stream, output int bad);
    bad = 0;
    send_sel(8'h43);
    for (int i = 0; i < 31; i++) begin
      if ((~ser_do_low) !== exp_stream[i]) begin
        bad++;
        $display("  stream bit %0d: line %b expected %b", i, ~ser_do_low, exp_stream[i]);
      end
      ser_clk = 1'b1;
      wait_cyc(HALF);
      ser_clk = 1'b0;
      wait_cyc(HALF);
    end
    ser_ce = 1'b0;
    wait_cyc(12);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int bad;
    string tag;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);

    // R11: reset state
    chk("R11 image", disp_bits, '0);
    chk("R11 mode fields", ctl_now(), '0);
    chk("R11 line released", ser_do_low, 1'b0);
    chk("R11 no strobe", rd_pulses, 0);

    // Vector table: R1, R2, R3, R4
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  sel;
      int          n;
      logic [52:0] pay;
      sel = VEC[v][66:59];
      n   = int'(VEC[v][58:53]);
      pay = VEC[v][52:0];
      if (sel != 8'h42)  tag = "R1";
      else if (n != 53)  tag = "R4";
      else if (pay[52])  tag = "R3";
      else               tag = "R2";
      send_sel(sel);
      send_payload(pay, n);
      model_write(sel, n, pay);
      chk({tag, " image"}, disp_bits, disp_m);
      chk({tag, " mode fields"}, ctl_now(), ctl_m);
    end

    // R8: line released during a write frame even with a request pending
    key_req = 1'b1;
    send_sel(8'h42);
    chk("R8 released in write frame", ser_do_low, 1'b0);
    send_payload({1'b1, 7'h55, 45'h1357_9BDF_024}, 53);
    model_write(8'h42, 53, {1'b1, 7'h55, 45'h1357_9BDF_024});
    chk("R3 upper half keeps mode fields", ctl_now(), ctl_m);

    // R7: request indication between frames
    chk("R7 request shown", ser_do_low, 1'b1);
    chip_rst_n = 1'b0;
    wait_cyc(2);
    chk("R7 masked by chip reset", ser_do_low, 1'b0);
    key_req = 1'b0;
    chip_rst_n = 1'b1;
    wait_cyc(2);
    chk("R7 no request", ser_do_low, 1'b0);

    // R10: writes proceed under chip reset
    chip_rst_n = 1'b0;
    send_sel(8'h42);
    send_payload({1'b0, 7'b0011001, 45'h0C3C_3C3C_3C3}, 53);
    model_write(8'h42, 53, {1'b0, 7'b0011001, 45'h0C3C_3C3C_3C3});
    chk("R10 image under chip reset", disp_bits, disp_m);
    chk("R10 mode fields under chip reset", ctl_now(), ctl_m);
    chip_rst_n = 1'b1;

    // R5, R9: read with pending request
    key_bits  = 30'h2B3C_4D5E;
    sleep_ack = 1'b1;
    key_req   = 1'b1;
    rd_pulses = 0;
    do_read({sleep_ack, key_bits}, bad);
    chk("R5 read stream mismatches", bad, 0);
    chk("R9 strobe count", rd_pulses, 1);

    // R6: read without request
    key_req   = 1'b0;
    rd_pulses = 0;
    do_read(31'h0, bad);
    chk("R6 zero stream mismatches", bad, 0);
    chk("R6 no strobe", rd_pulses, 0);

    // R1: unknown selector with request pending gives no strobe and no data
    key_req   = 1'b1;
    rd_pulses = 0;
    send_sel(8'h44);
    chk("R1 unknown selector leaves line released", ser_do_low, 1'b0);
    send_payload(53'h1F_FFFF_FFFF_FFFF, 53);
    chk("R1 unknown selector image", disp_bits, disp_m);
    chk("R1 unknown selector no strobe", rd_pulses, 0);
    key_req = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule